// File: doc/BRIEF.md
# Dual H-Bridge Input Decoder

This block turns two pairs of control inputs into the eight gate commands of two full H-bridges. Each bridge has two half-bridge legs (output 1 and output 2). Each leg has a high-side and a low-side switch. Bridge A is steered by two tri-level inputs that arrive already resolved into codes for low, high and floating. Bridge B is steered by two plain asynchronous logic inputs, which pass through a synchronizer first.

A wake input moves the block between sleep and run. A rising wake, or a reset release with wake already high, samples the bridge A codes. If both codes read floating at that moment, the block latches a paralleled mode in which the bridge B inputs drive both bridges identically. After each wake the block keeps every switch off for a programmable wake delay. Between turning one switch of a leg off and turning either switch of that leg on, it enforces a programmable dead time. A separate disable input forces all switches off at once.

Top module: `hb_input_decoder`

## Requirements
- R1: Bridge B decodes its synchronized input pair (in1, in2) as follows. 00 turns all four switches off (coast). 01 drives output 1 low and output 2 high. 10 drives output 1 high and output 2 low. 11 drives both outputs low (brake). On the ports, hs*[0] and ls*[0] belong to output 1, and hs*[1] and ls*[1] belong to output 2.
- R2: A bridge A input code is 2'b00 for low, 2'b01 for high, and 2'b10 or 2'b11 for floating. When both bridge A codes are definite and the block is not paralleled, bridge A follows the R1 table, using code bit 0 as the logic level.
- R3: When the block is not paralleled and either bridge A code reads floating, bridge A keeps the pair of levels it last decoded. After reset, that pair is 00 (coast).
- R4: Paralleled mode is latched only on the wake sample. It is entered only when both bridge A codes read floating at that sample. In paralleled mode, bridge A drives exactly what bridge B drives, and the bridge A codes have no effect.
- R5: Changing the bridge A codes while running never changes the mode. Paralleled mode is left only by a later wake sample taken with definite bridge A codes.
- R6: A switch turns on only after both switches of its leg have been off for DEAD_CYC consecutive cycles. A leg never goes from one switch straight to the other.
- R7: With wake low, all eight switch commands are off from the first clock edge after wake falls.
- R8: After the wake sample edge, all switches stay off through the next WAKE_CYC edges. Driving resumes on the edge after those.
- R9: While disable is high, all eight switch commands are off in the same cycle. After disable is released, a switch returns only after the R6 dead time.
- R10: A change on a bridge B input reaches the switches on the third clock edge when no dead time applies: two synchronizer stages, then the leg register. A change on the bridge A codes reaches the switches on the second edge.
- R11: During reset all switch commands are off and the block is not paralleled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low reset, acts as power-up |
| wakeIn | input | 1 | High to run, low to sleep |
| disableIn | input | 1 | Forces all switches off immediately |
| aCode1 | input | 2 | Resolved tri-level code, bridge A input 1 |
| aCode2 | input | 2 | Resolved tri-level code, bridge A input 2 |
| bIn1 | input | 1 | Bridge B logic input 1 (asynchronous) |
| bIn2 | input | 1 | Bridge B logic input 2 (asynchronous) |
| hsA | output | 2 | Bridge A high-side commands, bit 0 = output 1 |
| lsA | output | 2 | Bridge A low-side commands, bit 0 = output 1 |
| hsB | output | 2 | Bridge B high-side commands, bit 0 = output 1 |
| lsB | output | 2 | Bridge B low-side commands, bit 0 = output 1 |

## Verification
The hardest situation to reach is the mode latch. It is set only at the single wake-sample edge, so the stimulus must park the bridge A codes in the floating or definite state before wake rises and must then cycle sleep and wake again to leave the mode. The bench does this by toggling wake between phases. Between those phases it changes the bridge A codes while running, to show that the mode does not move. The hold behaviour is reached by sweeping all sixteen bridge A code pairs in an order where floating pairs follow definite ones. The bench tracks the last definite pair arithmetically, so each floating pair is checked against a known held state.

// File: rtl/hb_pkg.sv
package hb_pkg;

  typedef enum logic [1:0] {
    LEG_OFF = 2'd0,
    LEG_HI  = 2'd1,
    LEG_LO  = 2'd2
  } leg_t;

  typedef struct packed {
    logic sample;
    logic run;
  } hb_strobe_t;

  function automatic logic isFloat(input logic [1:0] code);
    return code[1];
  endfunction

  function automatic leg_t legTarget(input logic mine, input logic other);
    if (mine && !other) return LEG_HI;
    else if (other)     return LEG_LO;
    else                return LEG_OFF;
  endfunction

endpackage

// File: rtl/hb_leg.sv
module hb_leg
  import hb_pkg::*;
#(
  parameter int DEAD_CYC = 10
) (
  input  logic clk,
  input  logic rstN,
  input  logic en,
  input  leg_t tgt,
  output logic hsOut,
  output logic lsOut
);

  localparam int CW = $clog2(DEAD_CYC + 1);
  localparam logic [CW-1:0] CNT_MAX   = CW'(DEAD_CYC);
  localparam logic [CW-1:0] CNT_READY = CW'(DEAD_CYC - 1);

  leg_t curQ, curNext;
  logic [CW-1:0] offCnt, offCntNext;

  always_comb begin
    if (!en)                    curNext = LEG_OFF;
    else if (tgt == curQ)       curNext = curQ;
    else if (curQ != LEG_OFF)   curNext = LEG_OFF;
    else if (offCnt >= CNT_READY) curNext = tgt;
    else                        curNext = LEG_OFF;
  end

  always_comb begin
    if (curQ != LEG_OFF)       offCntNext = '0;
    else if (offCnt == CNT_MAX) offCntNext = offCnt;
    else                       offCntNext = offCnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      curQ   <= LEG_OFF;
      offCnt <= '0;
    end else begin
      curQ   <= curNext;
      offCnt <= offCntNext;
    end
  end

  assign hsOut = en && (curQ == LEG_HI);
  assign lsOut = en && (curQ == LEG_LO);

  // R6: a leg may only enter a driven state from the off state
  a_r6_no_direct_swap: assert property (@(posedge clk) disable iff (!rstN)
    (curQ != LEG_OFF && curQ != $past(curQ)) |-> $past(curQ) == LEG_OFF);

endmodule

// File: rtl/hb_ctrl.sv
module hb_ctrl
  import hb_pkg::*;
#(
  parameter int WAKE_CYC = 50000
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       wakeIn,
  output hb_strobe_t strb
);

  localparam int WW = $clog2(WAKE_CYC + 1);
  localparam logic [WW-1:0] WAKE_LAST = WW'(WAKE_CYC - 1);

  typedef enum logic [1:0] {ST_SLEEP, ST_WAKE, ST_RUN} ctrl_st_t;

  ctrl_st_t st, stNext;
  logic [WW-1:0] wakeCnt, wakeCntNext;
  logic sampleNow;

  always_comb begin
    stNext      = st;
    wakeCntNext = wakeCnt;
    sampleNow   = 1'b0;
    case (st)
      ST_SLEEP: begin
        if (wakeIn) begin
          sampleNow   = 1'b1;
          stNext      = ST_WAKE;
          wakeCntNext = '0;
        end
      end
      ST_WAKE: begin
        if (!wakeIn)                  stNext = ST_SLEEP;
        else if (wakeCnt == WAKE_LAST) stNext = ST_RUN;
        else                          wakeCntNext = wakeCnt + 1'b1;
      end
      ST_RUN: begin
        if (!wakeIn) stNext = ST_SLEEP;
      end
      default: stNext = ST_SLEEP;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      st      <= ST_SLEEP;
      wakeCnt <= '0;
    end else begin
      st      <= stNext;
      wakeCnt <= wakeCntNext;
    end
  end

  assign strb.sample = sampleNow;
  assign strb.run    = (st == ST_RUN);

  // R7: wake low stops driving by the next edge
  a_r7_sleep_stops_run: assert property (@(posedge clk) disable iff (!rstN)
    !wakeIn |=> !strb.run);

  // R8: run only begins when wake was held through the delay
  a_r8_run_needs_wake: assert property (@(posedge clk) disable iff (!rstN)
    $rose(strb.run) |-> $past(wakeIn));

endmodule

// File: rtl/hb_datapath.sv
module hb_datapath
  import hb_pkg::*;
#(
  parameter int DEAD_CYC    = 10,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  hb_strobe_t strb,
  input  logic       disableIn,
  input  logic [1:0] aCode1,
  input  logic [1:0] aCode2,
  input  logic       bIn1,
  input  logic       bIn2,
  output logic [1:0] hsA,
  output logic [1:0] lsA,
  output logic [1:0] hsB,
  output logic [1:0] lsB
);

  localparam int NUM_LEGS = 4;

  logic [SYNC_STAGES-1:0] sync1Q, sync2Q;
  logic bLvl1, bLvl2;
  logic [1:0] aLevel;
  logic parMode;
  logic legEn;
  logic [1:0] lvl [2];
  logic [NUM_LEGS-1:0] hsV, lsV;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sync1Q <= '0;
      sync2Q <= '0;
    end else begin
      sync1Q <= {sync1Q[SYNC_STAGES-2:0], bIn1};
      sync2Q <= {sync2Q[SYNC_STAGES-2:0], bIn2};
    end
  end

  assign bLvl1 = sync1Q[SYNC_STAGES-1];
  assign bLvl2 = sync2Q[SYNC_STAGES-1];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      aLevel  <= 2'b00;
      parMode <= 1'b0;
    end else begin
      if (strb.sample) parMode <= isFloat(aCode1) && isFloat(aCode2);
      if (!isFloat(aCode1) && !isFloat(aCode2)) aLevel <= {aCode1[0], aCode2[0]};
    end
  end

  assign lvl[0] = parMode ? {bLvl1, bLvl2} : aLevel;
  assign lvl[1] = {bLvl1, bLvl2};
  assign legEn  = strb.run && !disableIn;

  for (genvar g = 0; g < NUM_LEGS; g++) begin : gLeg
    localparam int BR   = g / 2;
    localparam int SIDE = g % 2;
    leg_t tgt;
    assign tgt = (SIDE == 0) ? legTarget(lvl[BR][1], lvl[BR][0])
                             : legTarget(lvl[BR][0], lvl[BR][1]);
    hb_leg #(.DEAD_CYC(DEAD_CYC)) uLeg (
      .clk  (clk),
      .rstN (rstN),
      .en   (legEn),
      .tgt  (tgt),
      .hsOut(hsV[g]),
      .lsOut(lsV[g])
    );
  end

  assign hsA = hsV[1:0];
  assign lsA = lsV[1:0];
  assign hsB = hsV[3:2];
  assign lsB = lsV[3:2];

  // R3: a floating bridge A code freezes the held level pair
  a_r3_hold_on_float: assert property (@(posedge clk) disable iff (!rstN)
    (isFloat(aCode1) || isFloat(aCode2)) |=> $stable(aLevel));

  // R4 / R5: the mode only moves on a wake sample
  a_r4_mode_only_on_sample: assert property (@(posedge clk) disable iff (!rstN)
    !strb.sample |=> $stable(parMode));

endmodule

// File: rtl/hb_input_decoder.sv
module hb_input_decoder
  import hb_pkg::*;
#(
  parameter int WAKE_CYC    = 50000,
  parameter int DEAD_CYC    = 10,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       wakeIn,
  input  logic       disableIn,
  input  logic [1:0] aCode1,
  input  logic [1:0] aCode2,
  input  logic       bIn1,
  input  logic       bIn2,
  output logic [1:0] hsA,
  output logic [1:0] lsA,
  output logic [1:0] hsB,
  output logic [1:0] lsB
);

  hb_strobe_t strb;

  hb_ctrl #(.WAKE_CYC(WAKE_CYC)) uCtrl (
    .clk   (clk),
    .rstN  (rstN),
    .wakeIn(wakeIn),
    .strb  (strb)
  );

  hb_datapath #(.DEAD_CYC(DEAD_CYC), .SYNC_STAGES(SYNC_STAGES)) uDp (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .disableIn(disableIn),
    .aCode1   (aCode1),
    .aCode2   (aCode2),
    .bIn1     (bIn1),
    .bIn2     (bIn2),
    .hsA      (hsA),
    .lsA      (lsA),
    .hsB      (hsB),
    .lsB      (lsB)
  );

  // R8: when driving resumes, every switch starts from off
  a_r8_quiet_at_run_start: assert property (@(posedge clk) disable iff (!rstN)
    $rose(strb.run) |-> ({hsA, lsA, hsB, lsB} == 8'h00));

endmodule

// File: tb/sim_hb_input_decoder.sv
module sim_hb_input_decoder;

  localparam int W = 20;
  localparam int D = 3;
  localparam logic [1:0] CL = 2'b00, CH = 2'b01, CZ = 2'b10;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic wakeIn = 1'b1;
  logic disableIn = 1'b0;
  logic [1:0] aCode1 = CL, aCode2 = CL;
  logic bIn1 = 1'b0, bIn2 = 1'b0;
  logic [1:0] hsA, lsA, hsB, lsB;
  int nChk = 0;
  int nErr = 0;
  logic done = 1'b0;

  always #10 clk = ~clk;

  hb_input_decoder #(.WAKE_CYC(W), .DEAD_CYC(D), .SYNC_STAGES(2)) u0 (
    .clk(clk), .rstN(rstN), .wakeIn(wakeIn), .disableIn(disableIn),
    .aCode1(aCode1), .aCode2(aCode2), .bIn1(bIn1), .bIn2(bIn2),
    .hsA(hsA), .lsA(lsA), .hsB(hsB), .lsB(lsB)
  );

  wire [3:0] brA = {hsA, lsA};
  wire [3:0] brB = {hsB, lsB};

  function automatic logic [3:0] expBr(input logic i1, input logic i2);
    return {i2 & ~i1, i1 & ~i2, i1, i2};
  endfunction

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #5;
  endtask

  task automatic chk(input string tag, input logic [3:0] act, input logic [3:0] exp);
    nChk++;
    if (act !== exp) begin
      nErr++;
      $display("FAIL %s actual=%b expected=%b", tag, act, exp);
    end
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      nErr++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  CHECKS %0d ERRORS %0d", nChk, nErr);
      $finish;
    end
  end

  initial begin
    logic [1:0] held;
    bIn1 = 1'b1; bIn2 = 1'b0;
    step(3);
    chk("R11 reset A", brA, 4'b0000);
    chk("R11 reset B", brB, 4'b0000);
    rstN = 1'b1;
    // R8: first edge samples, then WAKE_CYC quiet edges
    step(1);
    step(W);
    chk("R8 quiet B", brB, 4'b0000);
    step(1);
    chk("R8 resume B", brB, expBr(1, 0));
    chk("R3 reset hold coast A", brA, 4'b0000);
    // R10 / R6: forward to reverse on bridge B
    bIn1 = 1'b0; bIn2 = 1'b1;
    for (int n = 1; n <= 8; n++) begin
      step(1);
      if (n < 3)          chk("R10 sync latency", brB, expBr(1, 0));
      else if (n < 3 + D) chk("R6 dead gap", brB, 4'b0000);
      else                chk("R6 after dead", brB, expBr(0, 1));
    end
    // R1 / R2 / R3 sweep of all code pairs
    held = 2'b00;
    for (int i = 0; i < 16; i++) begin
      logic [1:0] c1, c2;
      c1 = 2'(i >> 2); c2 = 2'(i);
      aCode1 = c1; aCode2 = c2;
      bIn1 = c2[1]; bIn2 = c2[0];
      step(D + 6);
      chk("R1 decode B", brB, expBr(c2[1], c2[0]));
      if (c1[1] || c2[1]) chk("R3 hold A", brA, expBr(held[1], held[0]));
      else begin
        held = {c1[0], c2[0]};
        chk("R2 decode A", brA, expBr(held[1], held[0]));
      end
    end
    // R9 disable
    aCode1 = CH; aCode2 = CL; bIn1 = 1'b1; bIn2 = 1'b0;
    step(D + 6);
    chk("R2 forward A", brA, expBr(1, 0));
    disableIn = 1'b1;
    #1;
    chk("R9 disable A", brA, 4'b0000);
    chk("R9 disable B", brB, 4'b0000);
    step(1);
    disableIn = 1'b0;
    for (int n = 1; n <= D; n++) begin
      step(1);
      if (n < D) chk("R9 release dead", brA, 4'b0000);
      else       chk("R9 release drive", brA, expBr(1, 0));
    end
    // R7 sleep
    wakeIn = 1'b0;
    step(1);
    chk("R7 sleep A", brA, 4'b0000);
    chk("R7 sleep B", brB, 4'b0000);
    // R4 enter paralleled mode
    aCode1 = CZ; aCode2 = 2'b11;
    step(2);
    wakeIn = 1'b1;
    bIn1 = 1'b0; bIn2 = 1'b1;
    step(W + D + 4);
    chk("R4 par A follows B", brA, expBr(0, 1));
    chk("R4 par B", brB, expBr(0, 1));
    bIn1 = 1'b1; bIn2 = 1'b1;
    step(D + 6);
    chk("R4 par brake A", brA, expBr(1, 1));
    // R5 definite codes while running do not leave the mode
    aCode1 = CH; aCode2 = CL; bIn1 = 1'b0; bIn2 = 1'b1;
    step(D + 6);
    chk("R5 mode kept A", brA, expBr(0, 1));
    // R5 leave via sleep and wake with definite codes
    wakeIn = 1'b0;
    step(2);
    wakeIn = 1'b1;
    step(W + D + 4);
    chk("R5 normal A", brA, expBr(1, 0));
    chk("R5 normal B", brB, expBr(0, 1));
    // R4 a single floating code does not enter the mode
    wakeIn = 1'b0;
    step(2);
    aCode1 = CZ; aCode2 = CL;
    wakeIn = 1'b1;
    step(W + D + 4);
    chk("R4 no par, A held", brA, expBr(1, 0));
    chk("R4 no par B", brB, expBr(0, 1));
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", nChk, nErr);
    $finish;
  end

endmodule